// File: doc/BRIEF.md
# Memory-Based FIR/IIR Filter Engine

This block is a filter engine that keeps a sample history and a coefficient set in two small internal RAMs. It computes one output for each sample the host writes. A host sets a tap count, the base address of the history window, the base address of the coefficient window and the filter kind. It then sets the run bit and streams samples in through one register, collecting results from another. Two status flags support polling: one shows that the input register is free, and one shows that an unread result is waiting.

The engine forms each result with a single multiplier. It adds one product per clock into a wide accumulator and clamps the final value to the signed sample width. In FIR mode the history holds past inputs. An optional warm-up phase can take the first tap-count-minus-one samples as history only. In IIR mode the history holds past outputs instead, there is never a warm-up, and every sample written is filtered. The host can write and read both RAMs through address windows while the engine is stopped.

The host register space is `reg_addr[AW+1:AW]`, where AW = log2(DEPTH) and DEPTH is a power of two, at least 8. Region 00 holds the registers, selected by `reg_addr[2:0]`: 0 control and status, 1 tap count, 2 history base, 3 coefficient base, 4 sample in (write), 5 result out (read). Region 10 is the history RAM and region 11 is the coefficient RAM. In both, the word is chosen by `reg_addr[AW-1:0]`.

Top module: `filt_cop`

## Requirements
- R1: After reset the control/status word reads 0x000010 and the result register reads 0. Control/status bits are: bit0 run, bit1 IIR kind, bit2 skip warm-up, bit4 input free, bit5 result waiting.
- R2: A tap count write is stored clamped to the range 1..DEPTH, so 0 reads back as 1 and values above DEPTH read back as DEPTH. Writes to the tap count, history base and coefficient base are ignored while the run bit is set.
- R3: While stopped, host writes to the RAM windows change the addressed word and host reads return it. RAM window writes made while running are ignored.
- R4: In FIR mode with skip warm-up clear, the first T−1 accepted samples after the run bit is set are stored in history slots 0..T−2. They give no result: the input-free flag returns to 1 while the result-waiting flag stays 0.
- R5: History slot s lives at history address (base + s) mod DEPTH. In FIR mode a filtered sample is written to slot p. The result is Σ_{k=0}^{T−1} coef[(cbase+k) mod DEPTH] · slot((p−k) mod T). Afterwards p advances modulo T and starts at 0 when running begins.
- R6: In FIR mode with skip warm-up set, the first accepted sample is filtered at once against a history that the host loaded beforehand, with x[−j] in slot T−j.
- R7: In IIR mode the skip warm-up bit has no effect, and the first accepted sample gives a result. The result is x + Σ_{k=1}^{T−1} coef[(cbase+k) mod DEPTH] · slot((p−k) mod T). The clamped result is then stored in slot p.
- R8: Results are clamped to the signed 24-bit range −8388608..8388607.
- R9: A sample write is accepted only while running and while the input-free flag is 1. Acceptance clears the flag. A sample write at any other time is ignored.
- R10: A result sets the result-waiting flag and the input-free flag together. The result register and the flag then hold until the host reads the result register, which clears the flag. A newer result waits inside the engine and does not overwrite the unread one.
- R11: Clearing the run bit stops any computation in progress, resets the warm-up count and the slot pointer, and brings the flags back to input free and no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (only the result register has a read side effect) |
| reg_addr | input | AW+2 | Host address: region and register or RAM word |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, combinational from the address |

## Verification
On every cycle the assertions check the following. The flags must be idle whenever the run bit is clear. The input-free flag may fall only when a sample write is made while running. An unread result must keep its value and its flag. A result must arrive together with the freed input. The slot pointer and the tap count must stay inside their legal ranges. The arithmetic can only be shown by the bench's scenarios, which compare each result against a shadow model of both RAMs. These scenarios cover warm-up versus preloaded history, IIR feedback, clamping at both limits, ignored writes, the stalled second result and the restart after a stop.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ACCEPT, ST_RUN, ST_DONE} fc_state_e;

    localparam logic [1:0] RGN_REG  = 2'b00;
    localparam logic [1:0] RGN_DATA = 2'b10;
    localparam logic [1:0] RGN_COEF = 2'b11;

    localparam logic [2:0] IX_CTRL  = 3'd0;
    localparam logic [2:0] IX_TAPS  = 3'd1;
    localparam logic [2:0] IX_DBASE = 3'd2;
    localparam logic [2:0] IX_CBASE = 3'd3;
    localparam logic [2:0] IX_DIN   = 3'd4;
    localparam logic [2:0] IX_DOUT  = 3'd5;

    localparam int B_RUN   = 0;
    localparam int B_IIR   = 1;
    localparam int B_SKIP  = 2;
    localparam int B_EMPTY = 4;
    localparam int B_FULL  = 5;
endpackage

// File: rtl/fc_ram.sv
module fc_ram #(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fc_mac.sv
module fc_mac #(
    parameter int DW    = 24,
    parameter int ACC_W = 56
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [DW-1:0]    coef_i,
    input  logic signed [DW-1:0]    samp_i,
    output logic signed [ACC_W-1:0] sum_o,
    output logic        [DW-1:0]    sat_o
);
    localparam int PW = 2 * DW;
    localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;

    always_comb begin
        prod  = coef_i * samp_i;
        sum_o = acc_i + {{(ACC_W-PW){prod[PW-1]}}, prod};
        if (acc_i > MAXV)      sat_o = MAXV[DW-1:0];
        else if (acc_i < MINV) sat_o = MINV[DW-1:0];
        else                   sat_o = acc_i[DW-1:0];
    end
endmodule

// File: rtl/filt_cop.sv
module filt_cop
    import fc_pkg::*;
#(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int ACC_W = 56,
    localparam int AW   = $clog2(DEPTH),
    localparam int TW   = AW + 1,
    localparam int HAW  = AW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [HAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata
);
    typedef struct packed {
        logic             run;
        logic             iir;
        logic             skip;
        logic [TW-1:0]    taps;
        logic [AW-1:0]    dbase;
        logic [AW-1:0]    cbase;
        fc_state_e        state;
        logic [DW-1:0]    din;
        logic [DW-1:0]    dout;
        logic             in_empty;
        logic             out_full;
        logic [TW-1:0]    ptr;
        logic [TW-1:0]    cnt;
        logic [TW-1:0]    k;
        logic [TW-1:0]    idx;
        logic [ACC_W-1:0] acc;
    } fc_st_t;

    fc_st_t q, d;

    logic [1:0]       rgn;
    logic [2:0]       ix;
    logic             is_reg, din_wr, dout_rd;
    logic [TW-1:0]    last;
    logic             eng_we;
    logic [DW-1:0]    eng_wdata;
    logic             dram_we, cram_we;
    logic [AW-1:0]    dram_waddr, dram_raddr, cram_raddr;
    logic [DW-1:0]    dram_wdata, dram_rdata, cram_rdata;
    logic [ACC_W-1:0] mac_sum;
    logic [DW-1:0]    mac_sat;
    logic [DW-1:0]    status;

    function automatic logic [TW-1:0] slot_inc(input logic [TW-1:0] s, input logic [TW-1:0] lim);
        return (s == lim) ? '0 : s + 1'b1;
    endfunction

    function automatic logic [TW-1:0] slot_dec(input logic [TW-1:0] s, input logic [TW-1:0] lim);
        return (s == '0) ? lim : s - 1'b1;
    endfunction

    function automatic logic [TW-1:0] clamp_taps(input logic [DW-1:0] w);
        if (w == '0)              return TW'(1);
        else if (w > DW'(DEPTH))  return TW'(DEPTH);
        else                      return w[TW-1:0];
    endfunction

    assign rgn     = reg_addr[HAW-1:AW];
    assign ix      = reg_addr[2:0];
    assign is_reg  = (rgn == RGN_REG);
    assign din_wr  = reg_wr && is_reg && (ix == IX_DIN);
    assign dout_rd = reg_rd && is_reg && (ix == IX_DOUT);
    assign last    = q.taps - 1'b1;

    always_comb begin
        d         = q;
        eng_we    = 1'b0;
        eng_wdata = q.din;
        if (reg_wr && is_reg) begin
            case (ix)
                IX_CTRL: begin
                    d.run  = reg_wdata[B_RUN];
                    d.iir  = reg_wdata[B_IIR];
                    d.skip = reg_wdata[B_SKIP];
                end
                IX_TAPS:  if (!q.run) d.taps  = clamp_taps(reg_wdata);
                IX_DBASE: if (!q.run) d.dbase = reg_wdata[AW-1:0];
                IX_CBASE: if (!q.run) d.cbase = reg_wdata[AW-1:0];
                default: ;
            endcase
        end
        if (din_wr && q.run && q.in_empty && q.state == ST_IDLE) begin
            d.din      = reg_wdata;
            d.in_empty = 1'b0;
            d.state    = ST_ACCEPT;
        end
        if (dout_rd) d.out_full = 1'b0;

        case (q.state)
            ST_ACCEPT: begin
                if (!q.iir && !q.skip && q.cnt < last) begin
                    eng_we     = 1'b1;
                    d.ptr      = slot_inc(q.ptr, last);
                    d.cnt      = q.cnt + 1'b1;
                    d.in_empty = 1'b1;
                    d.state    = ST_IDLE;
                end else if (!q.iir) begin
                    eng_we  = 1'b1;
                    d.acc   = '0;
                    d.k     = '0;
                    d.idx   = q.ptr;
                    d.state = ST_RUN;
                end else begin
                    d.acc   = {{(ACC_W-DW){q.din[DW-1]}}, q.din};
                    d.k     = TW'(1);
                    d.idx   = slot_dec(q.ptr, last);
                    d.state = (last == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                d.acc = mac_sum;
                d.k   = q.k + 1'b1;
                d.idx = slot_dec(q.idx, last);
                if (q.k == last) d.state = ST_DONE;
            end
            ST_DONE: begin
                if (!q.out_full) begin
                    d.dout     = mac_sat;
                    d.out_full = 1'b1;
                    d.in_empty = 1'b1;
                    d.ptr      = slot_inc(q.ptr, last);
                    d.state    = ST_IDLE;
                    if (q.iir) begin
                        eng_we    = 1'b1;
                        eng_wdata = mac_sat;
                    end
                end
            end
            default: ;
        endcase

        if (!d.run) begin
            d.state    = ST_IDLE;
            d.in_empty = 1'b1;
            d.out_full = 1'b0;
            d.ptr      = '0;
            d.cnt      = '0;
            d.k        = '0;
            d.idx      = '0;
            d.acc      = '0;
            d.dout     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.taps     <= TW'(1);
            q.in_empty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dram_we    = q.run ? eng_we : (reg_wr && rgn == RGN_DATA);
    assign dram_waddr = q.run ? q.dbase + q.ptr[AW-1:0] : reg_addr[AW-1:0];
    assign dram_wdata = q.run ? eng_wdata : reg_wdata;
    assign dram_raddr = q.run ? q.dbase + q.idx[AW-1:0] : reg_addr[AW-1:0];
    assign cram_we    = !q.run && reg_wr && rgn == RGN_COEF;
    assign cram_raddr = q.run ? q.cbase + q.k[AW-1:0] : reg_addr[AW-1:0];

    fc_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_hist (
        .clk(clk), .we(dram_we), .waddr(dram_waddr), .wdata(dram_wdata),
        .raddr(dram_raddr), .rdata(dram_rdata)
    );

    fc_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_coef (
        .clk(clk), .we(cram_we), .waddr(reg_addr[AW-1:0]), .wdata(reg_wdata),
        .raddr(cram_raddr), .rdata(cram_rdata)
    );

    fc_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
        .acc_i($signed(q.acc)), .coef_i($signed(cram_rdata)), .samp_i($signed(dram_rdata)),
        .sum_o(mac_sum), .sat_o(mac_sat)
    );

    always_comb begin
        status          = '0;
        status[B_RUN]   = q.run;
        status[B_IIR]   = q.iir;
        status[B_SKIP]  = q.skip;
        status[B_EMPTY] = q.in_empty;
        status[B_FULL]  = q.out_full;
        reg_rdata       = '0;
        case (rgn)
            RGN_REG: begin
                case (ix)
                    IX_CTRL:  reg_rdata = status;
                    IX_TAPS:  reg_rdata = {{(DW-TW){1'b0}}, q.taps};
                    IX_DBASE: reg_rdata = {{(DW-AW){1'b0}}, q.dbase};
                    IX_CBASE: reg_rdata = {{(DW-AW){1'b0}}, q.cbase};
                    IX_DOUT:  reg_rdata = q.dout;
                    default:  reg_rdata = '0;
                endcase
            end
            RGN_DATA: reg_rdata = dram_rdata;
            RGN_COEF: reg_rdata = cram_rdata;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fc_chk.sv
module fc_chk #(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int TW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          din_wr,
    input logic          dout_rd,
    input logic          run,
    input logic          in_empty,
    input logic          out_full,
    input logic [DW-1:0] dout,
    input logic [TW-1:0] ptr,
    input logic [TW-1:0] taps
);
    AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (in_empty && !out_full)); // R11
    AST_TAKE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_empty) |-> $past(din_wr && run)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && out_full && !dout_rd) |=> (!run || (out_full && $stable(dout)))); // R10
    AST_RESULT_FREES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_full) |-> $rose(in_empty)); // R10
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ptr < taps)); // R5
    AST_TAPS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (taps != '0) && (taps <= TW'(DEPTH))); // R2
endmodule

bind filt_cop fc_chk #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .din_wr(din_wr), .dout_rd(dout_rd),
    .run(q.run), .in_empty(q.in_empty), .out_full(q.out_full),
    .dout(q.dout), .ptr(q.ptr), .taps(q.taps)
);

// File: tb/filt_cop_bench.sv
`timescale 1ns/1ps
module filt_cop_bench;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    logic [23:0] dsh [D];
    logic [23:0] csh [D];
    int m_taps, m_db, m_cb, m_ptr, m_cnt;
    bit m_iir, m_skip;

    always #2 clk = ~clk;

    filt_cop u_filt_cop (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic longint s24(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint sat24(input longint a);
        if (a > 64'sd8388607)  return 64'sd8388607;
        if (a < -64'sd8388608) return -64'sd8388608;
        return a;
    endfunction

    function automatic int hslot(input int s);
        return (m_db + s) % D;
    endfunction

    function automatic bit model_step(input logic [23:0] x, output longint y);
        longint acc;
        y = 0;
        if (!m_iir && !m_skip && m_cnt < m_taps - 1) begin
            dsh[hslot(m_ptr)] = x;
            m_ptr = (m_ptr + 1) % m_taps;
            m_cnt++;
            return 1'b0;
        end
        if (!m_iir) begin
            dsh[hslot(m_ptr)] = x;
            acc = 0;
            for (int k = 0; k < m_taps; k++)
                acc += s24(csh[(m_cb + k) % D]) * s24(dsh[hslot((m_ptr - k + m_taps) % m_taps)]);
            y = sat24(acc);
        end else begin
            acc = s24(x);
            for (int k = 1; k < m_taps; k++)
                acc += s24(csh[(m_cb + k) % D]) * s24(dsh[hslot((m_ptr - k + m_taps) % m_taps)]);
            y = sat24(acc);
            dsh[hslot(m_ptr)] = y[23:0];
        end
        m_ptr = (m_ptr + 1) % m_taps;
        return 1'b1;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [5:0] a, input logic [23:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [23:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic poll(input int bitpos);
        logic [23:0] v;
        int n = 0;
        do begin brd(6'h00, v); n++; end while (!v[bitpos] && n < 200);
    endtask

    task automatic ld_hist(input int a, input logic [23:0] v);
        bwr(6'h20 | 6'(a), v); dsh[a] = v;
    endtask

    task automatic ld_coef(input int a, input logic [23:0] v);
        bwr(6'h30 | 6'(a), v); csh[a] = v;
    endtask

    task automatic setup(input int t, input int db, input int cb, input bit iir, input bit skip);
        bwr(6'h00, 24'h0);
        bwr(6'h01, 24'(t)); bwr(6'h02, 24'(db)); bwr(6'h03, 24'(cb));
        m_taps = t; m_db = db; m_cb = cb; m_iir = iir; m_skip = skip;
        m_ptr = 0; m_cnt = 0;
        bwr(6'h00, {21'h0, skip, iir, 1'b1});
    endtask

    task automatic feed(input logic [23:0] x, input string req);
        logic [23:0] v;
        longint y;
        bit has;
        poll(4);
        bwr(6'h04, x);
        has = model_step(x, y);
        if (has) begin
            poll(5);
            brd(6'h05, v);
            check(req, s24(v), y);
        end else begin
            poll(4);
            brd(6'h00, v);
            check({req, " warm-up gives no result R4"}, longint'(v[5]), 0);
        end
    endtask

    function automatic logic [23:0] rnd_small();
        return 24'($signed($urandom_range(0, 4095)) - 2048);
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        longint ya, yb;
        bit h;
        void'($urandom(32'd7177));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(6'h00, v); check("R1 status after reset", longint'(v), 64'h10);
        brd(6'h05, v); check("R1 result after reset", longint'(v), 0);

        // R2 clamping of the tap count
        bwr(6'h01, 24'd0);  brd(6'h01, v); check("R2 taps 0 clamps to 1", longint'(v), 1);
        bwr(6'h01, 24'd40); brd(6'h01, v); check("R2 taps above depth clamps", longint'(v), D);

        // R3 host RAM access while stopped
        for (int i = 0; i < D; i++) begin
            ld_hist(i, rnd_small());
            ld_coef(i, rnd_small());
        end
        brd(6'h20 | 6'd7, v);  check("R3 history readback", longint'(v), longint'(dsh[7]));
        brd(6'h30 | 6'd12, v); check("R3 coefficient readback", longint'(v), longint'(csh[12]));

        // R4/R5 FIR with warm-up, windows that wrap around the RAM
        setup(4, 14, 13, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) feed(rnd_small(), "R4 preload");
        for (int i = 0; i < 20; i++) feed(rnd_small(), "R5 fir result");

        // R2 config ignored while running, R3 RAM writes ignored while running
        bwr(6'h01, 24'd9); brd(6'h01, v); check("R2 taps write ignored while running", longint'(v), 4);
        bwr(6'h02, 24'd3); brd(6'h02, v); check("R2 base write ignored while running", longint'(v), 14);
        bwr(6'h30 | 6'd5, 24'h123456);
        bwr(6'h00, 24'h0);
        brd(6'h30 | 6'd5, v); check("R3 coef write ignored while running", longint'(v), longint'(csh[5]));

        // R6 FIR without warm-up, host-loaded history
        setup(5, 0, 2, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) feed(rnd_small(), "R6 first sample filtered");

        // R7 IIR, skip bit clear must not matter
        bwr(6'h00, 24'h0);
        for (int i = 0; i < D; i++) ld_coef(i, 24'($signed($urandom_range(0, 8)) - 4));
        setup(3, 4, 0, 1'b1, 1'b0);
        for (int i = 0; i < 15; i++) feed(rnd_small(), "R7 iir result");
        setup(1, 4, 0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) feed(rnd_small(), "R7 iir single tap");

        // R8 saturation at both limits
        bwr(6'h00, 24'h0);
        ld_coef(0, 24'h7FFFFF); ld_coef(1, 24'h7FFFFF); ld_hist(9, 24'h7FFFFF);
        setup(2, 8, 0, 1'b0, 1'b1);
        feed(24'h7FFFFF, "R8 clamp high");
        feed(24'h800000, "R8 after max");
        feed(24'h800000, "R8 clamp low");

        // R9 second write while busy is ignored
        setup(3, 0, 4, 1'b0, 1'b1);
        bwr(6'h04, 24'd100);
        bwr(6'h04, 24'd555);
        h = model_step(24'd100, ya);
        poll(5);
        brd(6'h05, v); check("R9 busy write: first result", s24(v), ya);
        brd(6'h00, v); check("R9 busy write leaves no second result", longint'(v[5:4]), 1);
        feed(rnd_small(), "R9 history unaffected by ignored write");

        // R10 unread result holds, newer result waits
        poll(4);
        bwr(6'h04, 24'd77);  h = model_step(24'd77, ya);
        poll(5);
        bwr(6'h04, 24'd33);  h = model_step(24'd33, yb);
        repeat (20) @(negedge clk);
        brd(6'h00, v); check("R10 stalled: full set, input busy", longint'(v[5:4]), 2);
        brd(6'h05, v); check("R10 older result kept", s24(v), ya);
        poll(5);
        brd(6'h05, v); check("R10 newer result delivered", s24(v), yb);
        brd(6'h00, v); check("R10 read clears full", longint'(v[5]), 0);

        // R11 stop aborts, warm-up restarts
        setup(4, 6, 8, 1'b0, 1'b0);
        feed(rnd_small(), "R11 pre-abort");
        bwr(6'h04, 24'd999);
        bwr(6'h00, 24'h0);
        brd(6'h00, v); check("R11 flags idle after stop", longint'(v), 64'h10);
        setup(4, 6, 8, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) feed(rnd_small(), "R11 warm-up restarts");
        for (int i = 0; i < 6; i++) feed(rnd_small(), "R11 results after restart");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule